// File: doc/BRIEF.md
# Audio DAC Serial Transmitter

This block drives an external stereo DAC over a three-wire serial link made of a bit clock, a channel-select line and a data line. A processor writes audio samples into an eight-entry first-in first-out buffer. The serializer takes one sample from the buffer at the start of every channel slot, left channel first. The bit clock is divided down from the master clock that enters the block. A rate bit says whether that master clock runs at 256 or 384 times the sample rate, and the divider is chosen so that one frame always lasts exactly that many master clocks.

Software sets up the slot width, the channel-select polarity and the data justification, loads eight samples, and then sets the run bit. Each time the buffer drains to four samples, a request flag asks for four more. If a slot starts while the buffer is empty, that slot is sent as zeros and an under-run flag is latched. The bit clock and the channel-select timing keep running through an under-run. Each flag has its own interrupt enable, and a global enable gates both of them onto one interrupt line.

Top module: `audio_serial_tx`

## Requirements
- R1: After reset, bclk, sd, sreq, udrn and irq are low and ws is high (the right-channel level at polarity 0). Format register 0 resets to 0x08: justification 1, polarity 0, 16-bit slots, 256x ratio.
- R2: The bclk period in master clocks is 8 for 16-bit slots at 256x, 4 for 32-bit slots at 256x, 12 for 16-bit slots at 384x and 6 for 32-bit slots at 384x. Register 0 bit 0 selects 384x and bit 1 selects 32-bit slots. bclk sits low while stopped.
- R3: sd and ws change only on a falling bclk edge. Each channel slot is 16 or 32 bclk periods long, and the sample is sent MSB first.
- R4: When register 0 bit 2 is clear, ws is low for the left slot and high for the right slot. When it is set, the levels are swapped. ws changes at the falling edge that begins a slot.
- R5: Register 0 bits 7:3 give the slot bit index that carries the sample MSB. The bits before it, and the bits after the sample's LSB or past the slot end, are zero.
- R6: The buffer holds 8 samples and hands them out in write order, alternating left and right. A sample written while the buffer is full is dropped.
- R7: sreq is high exactly when the run bit is set and the buffer holds 4 or fewer samples.
- R8: A slot that begins with an empty buffer is sent as zeros and sets udrn, while bclk keeps its period. udrn stays set until the next sample write.
- R9: irq = reg1[3] AND ((reg1[2] AND sreq) OR (reg1[1] AND udrn)).
- R10: Register 1 bit 0 is the run bit. Clearing it stops bclk low, holds sd low and restarts the frame at the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (256x or 384x the sample rate) |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel | input | 1 | Register select: 0 format, 1 run and interrupt enables |
| cfg_wdata | input | 8 | Control register write data |
| smp_we | input | 1 | Sample write strobe |
| smp_data | input | SAMPLE_W | Sample written to the buffer |
| bclk | output | 1 | Serial bit clock |
| ws | output | 1 | Channel select |
| sd | output | 1 | Serial data, valid at the rising bclk edge |
| sreq | output | 1 | Refill request flag |
| udrn | output | 1 | Under-run flag |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its defaults: 16-bit samples, an 8-entry buffer and a refill mark of 4. With these values, a ninth write before the run bit overflows the buffer, and the ninth slot runs the buffer dry within about 1200 clocks. The 16-bit sample shows the truncation that happens in 16-bit slots and the zero padding that fills 32-bit slots. All four clock ratios, both polarities, and justifications of 0, 1, 2, 3 and 20 are covered.

// File: rtl/audio_serial_tx.sv
module audio_serial_tx #(
  parameter int SAMPLE_W = 16,
  parameter int DEPTH    = 8,
  parameter int LOW_MARK = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                cfg_sel,
  input  logic [7:0]          cfg_wdata,
  input  logic                smp_we,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                bclk,
  output logic                ws,
  output logic                sd,
  output logic                sreq,
  output logic                udrn,
  output logic                irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [4:0] just;
  logic       pol, wide, hr;
  logic       run, udrn_ie, sreq_ie, irq_en;

  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [SAMPLE_W-1:0] cur, cur_sh;
  logic [PW-1:0]       wp, rp;
  logic [CW-1:0]       count;

  logic [2:0] cnt, hdiv;
  logic [5:0] bitpos, nxt_pos, pin, slot_bits, last_pos;
  logic [6:0] off;
  logic       tick, fall, slot_start, pop, push, left, in_rng;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      just <= 5'd1; pol <= 1'b0; wide <= 1'b0; hr <= 1'b0;
      run <= 1'b0; udrn_ie <= 1'b0; sreq_ie <= 1'b0; irq_en <= 1'b0;
    end else if (cfg_we) begin
      if (!cfg_sel) {just, pol, wide, hr} <= cfg_wdata;
      else {irq_en, sreq_ie, udrn_ie, run} <= cfg_wdata[3:0];
    end

  assign slot_bits  = wide ? 6'd32 : 6'd16;
  assign last_pos   = wide ? 6'd63 : 6'd31;
  assign hdiv       = hr ? (wide ? 3'd3 : 3'd6) : (wide ? 3'd2 : 3'd4);
  assign tick       = run && (cnt == hdiv - 3'd1);
  assign fall       = tick && bclk;
  assign nxt_pos    = (bitpos >= last_pos) ? 6'd0 : bitpos + 6'd1;
  assign slot_start = fall && (nxt_pos == 6'd0 || nxt_pos == slot_bits);
  assign pop        = slot_start && (count != '0);
  assign push       = smp_we && (count != CW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; bclk <= 1'b0; bitpos <= '1;
    end else if (!run) begin
      cnt <= '0; bclk <= 1'b0; bitpos <= '1;
    end else if (tick) begin
      cnt  <= '0;
      bclk <= ~bclk;
      if (bclk) bitpos <= nxt_pos;
    end else begin
      cnt <= cnt + 3'd1;
    end

  always_ff @(posedge clk)
    if (push) mem[wp] <= smp_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0; cur <= '0; udrn <= 1'b0;
    end else begin
      if (push) wp <= step(wp);
      if (pop) rp <= step(rp);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (!run) cur <= '0;
      else if (slot_start) cur <= pop ? mem[rp] : '0;
      if (slot_start && count == '0) udrn <= 1'b1;
      else if (smp_we) udrn <= 1'b0;
    end

  assign left   = bitpos < slot_bits;
  assign pin    = left ? bitpos : bitpos - slot_bits;
  assign off    = {1'b0, pin} - {2'b0, just};
  assign in_rng = ({1'b0, pin} >= {2'b0, just}) && (off < 7'(SAMPLE_W));
  assign cur_sh = cur << off;
  assign sd     = in_rng && cur_sh[SAMPLE_W-1];
  assign ws     = pol ? left : ~left;

  assign sreq = run && (count <= CW'(LOW_MARK));
  assign irq  = irq_en && ((sreq_ie && sreq) || (udrn_ie && udrn));
endmodule

// File: rtl/audio_serial_tx_chk.sv
module audio_serial_tx_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          smp_we,
  input logic          run,
  input logic          bclk,
  input logic          ws,
  input logic          sd,
  input logic          udrn,
  input logic [CW-1:0] count
);
  p_sd_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(cfg_we) && !$stable(sd)) |-> $fell(bclk));

  p_ws_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(cfg_we) && !$stable(ws)) |-> $fell(bclk));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_udrn_on_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(udrn) |-> ($past(count) == '0));

  p_udrn_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(udrn) && !$past(smp_we)) |-> udrn);

  p_bclk_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> !bclk);
endmodule

bind audio_serial_tx audio_serial_tx_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .smp_we(smp_we), .run(run),
  .bclk(bclk), .ws(ws), .sd(sd), .udrn(udrn), .count(count)
);

// File: tb/audio_serial_tx_bench.sv
`timescale 1ns/1ps
module audio_serial_tx_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0, smp_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [15:0] smp_data = '0;
  logic bclk, ws, sd, sreq, udrn, irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  audio_serial_tx u_audio_serial_tx (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .smp_we(smp_we), .smp_data(smp_data),
    .bclk(bclk), .ws(ws), .sd(sd), .sreq(sreq), .udrn(udrn), .irq(irq)
  );

  // {write reg0, reg0 value, expected bclk period}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 8'h08, 8'd8}, {1'b1, 8'h04, 8'd8}, {1'b1, 8'h0A, 8'd4},
    {1'b1, 8'h1F, 8'd6}, {1'b1, 8'h11, 8'd12}, {1'b1, 8'hA2, 8'd4}
  };

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_sim();
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 1'b0; smp_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_cfg(input logic sel, input logic [7:0] d);
    @(negedge clk); cfg_sel = sel; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wr_smp(input logic [15:0] d);
    @(negedge clk); smp_data = d; smp_we = 1'b1;
    @(negedge clk); smp_we = 1'b0;
  endtask

  function automatic logic [15:0] smp_val(input int v, input int k);
    return 16'(32'hA5C3 + v * 32'h0F1D + k * 32'h3A97);
  endfunction

  function automatic logic [31:0] exp_word(input logic [15:0] s, input int nb, input int just);
    logic [31:0] w = '0;
    for (int p = 0; p < nb; p++) begin
      logic b = 1'b0;
      if (p >= just && p - just < 16) b = s[15 - (p - just)];
      w = {w[30:0], b};
    end
    return w;
  endfunction

  task automatic wait_rise(output int cyc);
    logic pb = bclk;
    cyc = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (bclk && !pb) return;
      pb = bclk;
    end
  endtask

  task automatic collect_slot(input int nb, input logic ws_exp, output logic [31:0] w,
                              output bit ws_ok, output int per);
    int c;
    w = '0; ws_ok = 1'b1; per = 0;
    for (int b = 0; b < nb; b++) begin
      wait_rise(c);
      if (b == 1) per = c;
      w = {w[30:0], sd};
      if (ws !== ws_exp) ws_ok = 1'b0;
    end
  endtask

  initial begin
    logic [31:0] w, e;
    bit wsok, idle_ok;
    int per, c;

    do_reset();
    chk(bclk == 0 && sd == 0 && sreq == 0 && udrn == 0 && irq == 0 && ws == 1,
        "R1 reset outputs", {26'd0, bclk, sd, sreq, udrn, irq, ws}, 32'h1);

    for (int v = 0; v < 6; v++) begin
      logic [16:0] vec = VEC[v];
      logic [7:0] cfg = vec[15:8];
      int nb = cfg[1] ? 32 : 16;
      int just = int'(cfg[7:3]);
      logic pol = cfg[2];
      do_reset();
      if (vec[16]) wr_cfg(1'b0, cfg);
      for (int k = 0; k < 8; k++) wr_smp(smp_val(v, k));
      wr_cfg(1'b1, 8'h01);
      chk(sreq == 0, "R7 sreq low with full buffer", {31'd0, sreq}, 32'd0);
      wait_rise(c);
      for (int s = 0; s < 4; s++) begin
        collect_slot(nb, (s % 2 == 0) ? pol : ~pol, w, wsok, per);
        e = exp_word(smp_val(v, s), nb, just);
        chk(w == e, "R3 R5 R6 slot data", w, e);
        chk(wsok, "R4 ws level in slot", {31'd0, wsok}, 32'd1);
        if (s == 0) chk(per == int'(vec[7:0]), "R2 bclk period", per, {24'd0, vec[7:0]});
      end
      chk(sreq == 1, "R7 sreq with 4 left", {31'd0, sreq}, 32'd1);
      chk(udrn == 0, "R8 no under-run while fed", {31'd0, udrn}, 32'd0);
    end

    // R7 and R10: refill above the mark, then stop
    do_reset();
    for (int k = 0; k < 4; k++) wr_smp(smp_val(9, k));
    wr_cfg(1'b1, 8'h01);
    chk(sreq == 1, "R7 sreq at mark", {31'd0, sreq}, 32'd1);
    wr_smp(smp_val(9, 4));
    chk(sreq == 0, "R7 sreq clears above mark", {31'd0, sreq}, 32'd0);
    repeat (40) @(negedge clk);
    wr_cfg(1'b1, 8'h00);
    repeat (2) @(negedge clk);
    idle_ok = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (bclk !== 1'b0 || sd !== 1'b0 || sreq !== 1'b0) idle_ok = 1'b0;
    end
    chk(idle_ok, "R10 stopped link idle", {31'd0, idle_ok}, 32'd1);

    // R6, R8 and R9: overfill, then run dry
    do_reset();
    for (int k = 0; k < 9; k++) wr_smp(smp_val(7, k));
    wr_cfg(1'b1, 8'h0B);
    wait_rise(c);
    for (int s = 0; s < 8; s++) begin
      collect_slot(16, (s % 2 == 0) ? 1'b0 : 1'b1, w, wsok, per);
      e = exp_word(smp_val(7, s), 16, 1);
      chk(w == e, "R6 buffered order", w, e);
    end
    chk(udrn == 0, "R8 udrn low before dry slot", {31'd0, udrn}, 32'd0);
    collect_slot(16, 1'b0, w, wsok, per);
    chk(w == 32'd0, "R6 R8 dropped ninth sample, zero slot", w, 32'd0);
    chk(per == 8 && wsok, "R8 clock keeps running", per, 32'd8);
    chk(udrn == 1, "R8 udrn set", {31'd0, udrn}, 32'd1);
    chk(irq == 1, "R9 irq from under-run", {31'd0, irq}, 32'd1);
    wr_smp(16'h1234);
    chk(udrn == 0, "R8 udrn cleared by write", {31'd0, udrn}, 32'd0);
    chk(irq == 0, "R9 sreq source disabled", {31'd0, irq}, 32'd0);
    wr_cfg(1'b1, 8'h0F);
    chk(irq == 1, "R9 irq from sreq", {31'd0, irq}, 32'd1);
    wr_cfg(1'b1, 8'h07);
    chk(irq == 0, "R9 global enable off", {31'd0, irq}, 32'd0);

    finish_sim();
  end
endmodule